// File: doc/BRIEF.md
# 1-Wire Slave Bit-Level Transceiver

This block is the signalling layer of a single-wire slave. It watches a sensed copy of an open-drain line that idles high, and it pulls the line low through a separate pull-down output. All timing runs from a one-microsecond tick enable, so the block works at any system clock. A long low level from the master is recognised as a bus reset. The block then answers with a presence pulse and sends a one-cycle reset strobe upward, which aborts whatever the command layers were doing.

Every slot begins at a falling edge from the master, and that edge restarts the slot timer. If the upper layer has loaded a byte for transmission, the slot is a read slot. The block holds the line low for a 0 bit and leaves it released for a 1 bit. Otherwise the slot is a write slot, and the line level is sampled at a fixed delay after the edge. Received bits are gathered into bytes, least significant bit first. Program and blocking strobes from the master side come in as separate inputs and are passed upward as one-cycle pulses. They are suppressed while a reset and presence exchange is in progress.

Top module: `ow_slave_phy`

## Requirements
- R1: A line low for RESET_US (480) consecutive ticks raises busReset for exactly one clock while the line is still low. A low of 300 ticks raises no busReset and no presence pulse.
- R2: After the line rises at the end of a reset, the block waits PRES_WAIT_US (30) ticks and then drives lineDrvLow for PRES_US (120) ticks. Each interval is accurate to within one tick.
- R3: In a slot with no transmit byte queued, the line is sampled SAMPLE_US (15) ticks after the falling edge. A high level decodes as bit 1 and a low level as bit 0.
- R4: In a slot with a transmit bit queued, a 0 bit holds lineDrvLow from the cycle after the falling edge until SAMPLE_US ticks after it, and a 1 bit leaves the line released. In both cases the line is released after that point.
- R5: Received bits fill rxByte least significant bit first. After the eighth bit, rxValid pulses for one clock with the complete byte on rxByte.
- R6: txLoad takes txByte only while txReady is 1. txReady drops to 0 and returns to 1 after eight slots. A txLoad while txReady is 0 has no effect on the bits sent.
- R7: With no transmit byte queued, the block never pulls the line during a slot. The master therefore reads 1, and the slot is decoded as a received 1 bit.
- R8: A bus reset empties the transmit queue, so txReady is 1 on the next clock, and clears the partial received byte and its bit counter.
- R9: A one-clock pulse on progStrobe or blockStrobe appears one clock later on progPulse or blockPulse. It is dropped while a reset or presence exchange is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle enable once per microsecond |
| lineIn | input | 1 | Sensed level of the data line, synchronous to clk |
| lineDrvLow | output | 1 | 1 pulls the data line low |
| busReset | output | 1 | One-cycle strobe on a detected bus reset |
| rxByte | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe when rxByte is updated |
| txByte | input | 8 | Byte to transmit in read slots |
| txLoad | input | 1 | Load txByte when txReady is 1 |
| txReady | output | 1 | 1 when no transmit bits are pending |
| progStrobe | input | 1 | Program pulse indication from the master side |
| blockStrobe | input | 1 | Blocking pulse indication from the master side |
| progPulse | output | 1 | Forwarded program pulse |
| blockPulse | output | 1 | Forwarded blocking pulse |

## Verification
The assertions check several properties on every cycle. The reset strobe is one clock wide and occurs only while the line is low. It leaves the transmit queue empty on the next clock. The receive strobe never repeats on consecutive clocks, and a forwarded pulse always has an input strobe one clock before it. The presence wait and width, the sample point, the least-significant-bit-first byte order, and the value a master reads in each slot depend on whole slot sequences. Only the bench scenarios can show these: sweeps of transmitted and received byte values, a short low that is not a reset, a reset in the middle of a byte, and strobes that arrive during the presence pulse.

// File: rtl/owphy_pkg.sv
package owphy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_SLOT_END,
    ST_RST_LOW,
    ST_PRES_WAIT,
    ST_PRES_DRIVE
  } phyState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic clearAll;
    logic shiftRx;
    logic rxBit;
    logic shiftTx;
  } dpCtrl_t;

endpackage

// File: rtl/owphy_ctrl.sv
module owphy_ctrl
  import owphy_pkg::*;
#(
  parameter int RESET_US     = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_US      = 120,
  parameter int SAMPLE_US    = 15
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    usTick,
  input  logic    lineIn,
  input  logic    txPending,
  input  logic    txBit,
  input  logic    progStrobe,
  input  logic    blockStrobe,
  output dpCtrl_t ctl,
  output logic    lineDrvLow,
  output logic    busReset,
  output logic    progPulse,
  output logic    blockPulse
);

  localparam int LOW_W   = $clog2(RESET_US + 1);
  localparam int T_A     = (PRES_US > PRES_WAIT_US) ? PRES_US : PRES_WAIT_US;
  localparam int T_MAX   = (T_A > SAMPLE_US) ? T_A : SAMPLE_US;
  localparam int T_W     = $clog2(T_MAX + 1);
  localparam logic [LOW_W-1:0] LOW_SAT  = LOW_W'(RESET_US);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(RESET_US - 1);
  localparam logic [T_W-1:0]   T_SAT    = T_W'(T_MAX);
  localparam logic [T_W-1:0]   T_SAMPLE = T_W'(SAMPLE_US);
  localparam logic [T_W-1:0]   T_PWAIT  = T_W'(PRES_WAIT_US);
  localparam logic [T_W-1:0]   T_PRES   = T_W'(PRES_US);

  phyState_t        state, stateNext;
  logic             lineQ;
  logic [LOW_W-1:0] lowCnt;
  logic [T_W-1:0]   slotTimer;
  logic             readSlot, readSlotNext;
  logic             timerClr;
  logic             fallEdge;
  logic             detectOn;
  logic             resetHit;
  logic             fwdOk;

  assign fallEdge = lineQ & ~lineIn;
  assign detectOn = (state == ST_IDLE) || (state == ST_SLOT) || (state == ST_SLOT_END);
  assign resetHit = detectOn && !lineIn && usTick && (lowCnt == LOW_LAST);
  assign fwdOk    = (state != ST_RST_LOW) && (state != ST_PRES_WAIT) &&
                    (state != ST_PRES_DRIVE);

  always_comb begin
    stateNext    = state;
    readSlotNext = readSlot;
    timerClr     = 1'b0;
    ctl          = '0;
    busReset     = 1'b0;
    if (resetHit) begin
      stateNext    = ST_RST_LOW;
      ctl.clearAll = 1'b1;
      busReset     = 1'b1;
      readSlotNext = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (fallEdge) begin
            stateNext    = ST_SLOT;
            timerClr     = 1'b1;
            readSlotNext = txPending;
          end
        end
        ST_SLOT: begin
          if (slotTimer == T_SAMPLE) begin
            stateNext = ST_SLOT_END;
            if (readSlot) begin
              ctl.shiftTx = 1'b1;
            end else begin
              ctl.shiftRx = 1'b1;
              ctl.rxBit   = lineIn;
            end
          end
        end
        ST_SLOT_END: begin
          if (lineIn) stateNext = ST_IDLE;
        end
        ST_RST_LOW: begin
          if (lineIn) begin
            stateNext = ST_PRES_WAIT;
            timerClr  = 1'b1;
          end
        end
        ST_PRES_WAIT: begin
          if (slotTimer == T_PWAIT) begin
            stateNext = ST_PRES_DRIVE;
            timerClr  = 1'b1;
          end
        end
        ST_PRES_DRIVE: begin
          if (slotTimer == T_PRES) stateNext = ST_SLOT_END;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  assign lineDrvLow = (state == ST_PRES_DRIVE) ||
                      ((state == ST_SLOT) && readSlot && !txBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      lineQ      <= 1'b1;
      lowCnt     <= '0;
      slotTimer  <= '0;
      readSlot   <= 1'b0;
      progPulse  <= 1'b0;
      blockPulse <= 1'b0;
    end else begin
      state    <= stateNext;
      lineQ    <= lineIn;
      readSlot <= readSlotNext;
      if (lineIn) begin
        lowCnt <= '0;
      end else if (usTick && (lowCnt != LOW_SAT)) begin
        lowCnt <= lowCnt + 1'b1;
      end
      if (timerClr) begin
        slotTimer <= '0;
      end else if (usTick && (slotTimer != T_SAT)) begin
        slotTimer <= slotTimer + 1'b1;
      end
      progPulse  <= progStrobe && fwdOk;
      blockPulse <= blockStrobe && fwdOk;
    end
  end

endmodule

// File: rtl/owphy_datapath.sv
module owphy_datapath
  import owphy_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              txLoad,
  input  logic [DATA_W-1:0] txByte,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  output logic              txPending,
  output logic              txBit,
  output logic              txReady
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(DATA_W);

  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxNext;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] txShift;
  logic [CNT_W-1:0]  txLeft;

  assign rxNext    = {ctl.rxBit, rxShift[DATA_W-1:1]};
  assign txPending = (txLeft != '0);
  assign txReady   = (txLeft == '0);
  assign txBit     = txShift[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else if (ctl.clearAll) begin
      rxShift <= '0;
      bitCnt  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (ctl.shiftRx) begin
        rxShift <= rxNext;
        if (bitCnt == LAST_BIT) begin
          bitCnt  <= '0;
          rxByte  <= rxNext;
          rxValid <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearAll) begin
      txShift <= '1;
      txLeft  <= '0;
    end else if (ctl.shiftTx) begin
      txShift <= {1'b1, txShift[DATA_W-1:1]};
      txLeft  <= txLeft - 1'b1;
    end else if (txLoad && txReady) begin
      txShift <= txByte;
      txLeft  <= FULL;
    end
  end

endmodule

// File: rtl/ow_slave_phy.sv
module ow_slave_phy
  import owphy_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int RESET_US     = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_US      = 120,
  parameter int SAMPLE_US    = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              lineIn,
  output logic              lineDrvLow,
  output logic              busReset,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txLoad,
  output logic              txReady,
  input  logic              progStrobe,
  input  logic              blockStrobe,
  output logic              progPulse,
  output logic              blockPulse
);

  dpCtrl_t ctl;
  logic    txPending;
  logic    txBit;

  owphy_ctrl #(
    .RESET_US(RESET_US), .PRES_WAIT_US(PRES_WAIT_US),
    .PRES_US(PRES_US), .SAMPLE_US(SAMPLE_US)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .usTick(usTick), .lineIn(lineIn),
    .txPending(txPending), .txBit(txBit),
    .progStrobe(progStrobe), .blockStrobe(blockStrobe),
    .ctl(ctl), .lineDrvLow(lineDrvLow), .busReset(busReset),
    .progPulse(progPulse), .blockPulse(blockPulse)
  );

  owphy_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txLoad(txLoad), .txByte(txByte),
    .rxByte(rxByte), .rxValid(rxValid), .txPending(txPending),
    .txBit(txBit), .txReady(txReady)
  );

endmodule

// File: rtl/ow_slave_phy_chk.sv
module ow_slave_phy_chk (
  input logic clk,
  input logic rstN,
  input logic lineIn,
  input logic busReset,
  input logic rxValid,
  input logic txReady,
  input logic progStrobe,
  input logic blockStrobe,
  input logic progPulse,
  input logic blockPulse
);

  // R1
  reset_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !busReset);

  // R1
  reset_line_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReset |-> !lineIn);

  // R8
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (txReady && !rxValid));

  // R5
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R9
  prog_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    progPulse |-> $past(progStrobe));

  // R9
  block_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockPulse |-> $past(blockStrobe));

endmodule

bind ow_slave_phy ow_slave_phy_chk uChk (
  .clk(clk), .rstN(rstN), .lineIn(lineIn), .busReset(busReset),
  .rxValid(rxValid), .txReady(txReady), .progStrobe(progStrobe),
  .blockStrobe(blockStrobe), .progPulse(progPulse), .blockPulse(blockPulse)
);

// File: tb/sim_ow_slave_phy.sv
`timescale 1ns/1ps
module sim_ow_slave_phy;

  localparam int PRES_WAIT = 30;
  localparam int PRES_W    = 120;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       usTick = 1'b0;
  logic       mLow = 1'b0;
  logic       lineIn;
  logic       lineDrvLow, busReset, rxValid, txReady, progPulse, blockPulse;
  logic [7:0] rxByte;
  logic [7:0] txByte = 8'h00;
  logic       txLoad = 1'b0;
  logic       progStrobe = 1'b0, blockStrobe = 1'b0;
  logic [1:0] divCnt = '0;

  int checks = 0, failures = 0;
  int nReset = 0, nRx = 0, nProg = 0, nBlock = 0, cycles = 0;
  logic [7:0] lastRx = 8'h00;

  assign lineIn = ~(mLow | lineDrvLow);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    divCnt <= divCnt + 1'b1;
    usTick <= divCnt[0];
  end

  ow_slave_phy u0 (
    .clk(clk), .rstN(rstN), .usTick(usTick), .lineIn(lineIn),
    .lineDrvLow(lineDrvLow), .busReset(busReset), .rxByte(rxByte),
    .rxValid(rxValid), .txByte(txByte), .txLoad(txLoad), .txReady(txReady),
    .progStrobe(progStrobe), .blockStrobe(blockStrobe),
    .progPulse(progPulse), .blockPulse(blockPulse)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (busReset) nReset <= nReset + 1;
    if (rxValid) begin
      nRx    <= nRx + 1;
      lastRx <= rxByte;
    end
    if (progPulse) nProg <= nProg + 1;
    if (blockPulse) nBlock <= nBlock + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitUs(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!usTick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic writeBit(input bit b);
    mLow = 1'b1;
    waitUs(b ? 2 : 40);
    mLow = 1'b0;
    waitUs(b ? 46 : 8);
  endtask

  task automatic writeByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) writeBit(v[i]);
  endtask

  // returns read bit and whether the line was released late in the slot
  task automatic readBit(output bit b, output bit rel);
    mLow = 1'b1;
    waitUs(1);
    mLow = 1'b0;
    waitUs(8);
    b = lineIn;
    waitUs(16);
    rel = lineIn;
    waitUs(20);
  endtask

  task automatic readByte(output logic [7:0] v, output bit allRel);
    bit b, r;
    allRel = 1'b1;
    for (int i = 0; i < 8; i++) begin
      readBit(b, r);
      v[i] = b;
      allRel &= r;
    end
  endtask

  task automatic loadTx(input logic [7:0] v);
    txByte = v;
    txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0;
  endtask

  // full reset pulse with presence timing measurement
  task automatic resetSeq(output int waitT, output int widthT);
    mLow = 1'b1;
    waitUs(500);
    mLow = 1'b0;
    waitT = 0;
    while (!lineDrvLow && waitT < 300) begin
      waitUs(1);
      waitT++;
    end
    widthT = 0;
    while (lineDrvLow && widthT < 300) begin
      waitUs(1);
      widthT++;
    end
    waitUs(10);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w, wd, r0, x0;
    logic [7:0] rv;
    bit rel, b, r;
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    waitUs(3);

    // reset state
    check(!lineDrvLow && txReady && !rxValid && nReset == 0, "R8 reset state",
          {lineDrvLow, txReady, rxValid}, 3'b010);

    // R1 and R2: reset and presence timing
    resetSeq(w, wd);
    check(nReset == 1, "R1 reset strobe count", nReset, 1);
    check(w >= PRES_WAIT - 1 && w <= PRES_WAIT + 1, "R2 presence wait", w, PRES_WAIT);
    check(wd >= PRES_W - 1 && wd <= PRES_W + 1, "R2 presence width", wd, PRES_W);

    // R1: short low is no reset
    r0 = nReset;
    mLow = 1'b1;
    waitUs(300);
    mLow = 1'b0;
    x0 = 0;
    for (int i = 0; i < 200; i++) begin
      waitUs(1);
      if (lineDrvLow) x0++;
    end
    check(nReset == r0 && x0 == 0, "R1 short low ignored", nReset - r0 + x0, 0);
    // the short low was decoded as a 0 bit; resync the bit counter
    resetSeq(w, wd);

    // R3 R5: write sweep
    for (int i = 0; i < 64; i++) begin
      logic [7:0] v;
      v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 73 + 11) & 255);
      r0 = nRx;
      writeByte(v);
      check(nRx == r0 + 1 && lastRx == v, "R3 R5 write byte", lastRx, v);
    end

    // R4 R6: read sweep
    for (int i = 0; i < 64; i++) begin
      logic [7:0] v;
      v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 151 + 7) & 255);
      loadTx(v);
      check(!txReady, "R6 txReady low after load", txReady, 0);
      readByte(rv, rel);
      check(rv == v && rel, "R4 read byte", rv, v);
      check(txReady, "R6 txReady back after eight slots", txReady, 1);
    end

    // R7: idle read slots read 1 and decode as received 1 bits
    r0 = nRx;
    readByte(rv, rel);
    check(rv == 8'hFF, "R7 idle slots read ones", rv, 8'hFF);
    check(nRx == r0 + 1 && lastRx == 8'hFF, "R7 idle slots decoded as ones", lastRx, 8'hFF);

    // R6: load while busy ignored
    loadTx(8'h3C);
    loadTx(8'hC3);
    readByte(rv, rel);
    check(rv == 8'h3C, "R6 busy load ignored", rv, 8'h3C);

    // R8: reset mid-byte clears bit counter
    writeBit(1'b0); writeBit(1'b0); writeBit(1'b1);
    resetSeq(w, wd);
    r0 = nRx;
    writeByte(8'hA5);
    check(nRx == r0 + 1 && lastRx == 8'hA5, "R8 rx counter cleared", lastRx, 8'hA5);

    // R8: reset empties transmit queue
    loadTx(8'h00);
    readBit(b, r);
    resetSeq(w, wd);
    check(txReady, "R8 tx queue emptied", txReady, 1);
    readBit(b, r);
    check(b == 1'b1, "R8 no stale tx bit", b, 1);
    for (int i = 0; i < 7; i++) writeBit(1'b1);

    // R9: strobes forwarded in idle
    r0 = nProg; x0 = nBlock;
    progStrobe = 1'b1; @(negedge clk); progStrobe = 1'b0;
    blockStrobe = 1'b1; @(negedge clk); blockStrobe = 1'b0;
    waitUs(2);
    check(nProg == r0 + 1 && nBlock == x0 + 1, "R9 strobes forwarded",
          nProg - r0 + nBlock - x0, 2);

    // R9: strobes dropped during presence
    r0 = nProg; x0 = nBlock;
    mLow = 1'b1;
    waitUs(500);
    mLow = 1'b0;
    waitUs(60);
    progStrobe = 1'b1; blockStrobe = 1'b1;
    @(negedge clk);
    progStrobe = 1'b0; blockStrobe = 1'b0;
    waitUs(150);
    check(nProg == r0 && nBlock == x0, "R9 strobes dropped in presence",
          nProg - r0 + nBlock - x0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule